// File: doc/BRIEF.md
# Interrupt relocation vector selector

This block decides, for one interrupt at a time, whether the handler runs with address translation switched on, and at which address the handler starts. A processor core that can move its interrupt handlers to a relocated address range feeds it several inputs. These are the current translation and hypervisor state bits, the hypervisor state the interrupt will enter, the partition's relocation controls, the interrupt class and the unrelocated vector. The block returns three results: the effective relocation level, the final 64-bit handler address, and a flag that tells exception entry to force instruction and data translation on.

Four processor generations are supported through a model select input. The oldest never relocates. The two middle generations share one rule set, where a guest running with radix translation may pass its relocation level on to hypervisor-bound interrupts. The newest generation has a separate hypervisor relocation enable and drops the reserved level 2. Two relocation levels are kept internally: one for interrupts that enter guest state and one for interrupts that enter hypervisor state. The entered hypervisor state picks which of the two is used.

A request strobe launches a computation. The result is registered and appears one cycle later together with a one-cycle valid pulse. The outputs then hold until the next request.

Top module: `relocsel_top`

## Requirements
- R1: A `reqValid` high at a clock edge makes `outValid` high for exactly the following cycle, with `outLevel`, `outVector` and `outXlateOn` updated at that same edge. The outputs hold their values when no request is made. Reset clears all outputs to 0.
- R2: Exception classes 1 (system reset), 2 (machine check) and 3 (hypervisor maintenance) always give level 0. Class 0 is an ordinary interrupt.
- R3: With `genSel` = 0 (oldest generation) the level is always 0.
- R4: With `genSel` = 1 or 2, both internal levels start from `relocField`. If `curInstXlate` or `curDataXlate` is 0, the result is 0.
- R5: With `genSel` = 1 or 2, translation on, and a guest-to-hypervisor entry (`curHyp`=0, `newHyp`=1), the level is 0 when `radixGuest`=0 and equals `relocField` when `radixGuest`=1.
- R6: With `genSel` = 3, an interrupt entering hypervisor state (`newHyp`=1) uses 3 when `hypRelocEn`=1 and 0 otherwise. An interrupt entering guest state uses `relocField`.
- R7: With `genSel` = 3, a `relocField` value of 2 counts as 0.
- R8: With `genSel` = 3, the translation check zeroes the level only when `curHyp` equals `newHyp`. A 0-to-1 entry yields the hypervisor level whatever the translation bits are. A 1-to-0 entry yields the guest level.
- R9: For an ordinary entry (`sysCallVec`=0), `outVector` is `baseVector` OR an offset. The offset is 0 for levels 0 and 1, 0x18000 for level 2, and 0xC000000000004000 for level 3.
- R10: For a system-call-vectored entry (`sysCallVec`=1), `outVector` is `baseVector` OR 0xC000000000003000 when the level is 3, and `baseVector` OR 0x17000 for any other level.
- R11: `outXlateOn` is 1 exactly when the resulting level is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| genSel | input | 2 | Processor generation: 0 oldest, 1 and 2 middle, 3 newest |
| excClass | input | 2 | 0 ordinary, 1 system reset, 2 machine check, 3 hypervisor maintenance |
| curInstXlate | input | 1 | Instruction translation currently on |
| curDataXlate | input | 1 | Data translation currently on |
| curHyp | input | 1 | Currently in hypervisor state |
| newHyp | input | 1 | Interrupt enters hypervisor state |
| relocField | input | 2 | Partition relocation level field |
| hypRelocEn | input | 1 | Newest generation hypervisor relocation enable |
| radixGuest | input | 1 | Partition uses radix translation |
| baseVector | input | 64 | Unrelocated handler address |
| sysCallVec | input | 1 | Entry is a system-call-vectored call |
| outValid | output | 1 | One-cycle result pulse |
| outLevel | output | 2 | Effective relocation level |
| outVector | output | 64 | Final handler address |
| outXlateOn | output | 1 | Force translation on at entry |

## Verification
Each generation is swept over every combination of the translation bits, current and entered hypervisor state, the four relocation field values, the hypervisor enable and the radix bit. This separates the same-state, guest-to-hypervisor and hypervisor-to-guest paths, and tells apart the generations whose hypervisor level follows the field from the one that uses its own enable. The sweep is repeated for all four exception classes and for both entry kinds, so the real-mode classes and both offset tables are seen at every level. Directed cases cover the reset state, the valid pulse and output hold, and the reserved field value on the newest generation.

// File: rtl/relocsel_pkg.sv
package relocsel_pkg;

  typedef enum logic [1:0] {
    GEN_LEGACY = 2'd0,
    GEN_MID_A  = 2'd1,
    GEN_MID_B  = 2'd2,
    GEN_NEW    = 2'd3
  } gen_e;

  typedef enum logic [1:0] {
    CLS_ORDINARY   = 2'd0,
    CLS_SYS_RESET  = 2'd1,
    CLS_MACH_CHECK = 2'd2,
    CLS_HYP_MAINT  = 2'd3
  } cls_e;

  localparam int LEVEL_W = 2;

  // Control-to-datapath strobes
  typedef struct packed {
    logic               capture;
    logic               sysCall;
    logic [LEVEL_W-1:0] level;
  } strobe_t;

  localparam logic [63:0] OFS_ORD_L2   = 64'h0000_0000_0001_8000;
  localparam logic [63:0] OFS_ORD_L3   = 64'hC000_0000_0000_4000;
  localparam logic [63:0] OFS_SC_L3    = 64'hC000_0000_0000_3000;
  localparam logic [63:0] OFS_SC_OTHER = 64'h0000_0000_0001_7000;

endpackage

// File: rtl/relocsel_ctrl.sv
module relocsel_ctrl
  import relocsel_pkg::*;
(
  input  logic               reqValid,
  input  logic [1:0]         genSel,
  input  logic [1:0]         excClass,
  input  logic               curInstXlate,
  input  logic               curDataXlate,
  input  logic               curHyp,
  input  logic               newHyp,
  input  logic [LEVEL_W-1:0] relocField,
  input  logic               hypRelocEn,
  input  logic               radixGuest,
  input  logic               sysCallVec,
  output strobe_t            strobes
);

  localparam logic [LEVEL_W-1:0] LVL_ZERO = '0;
  localparam logic [LEVEL_W-1:0] LVL_MAX  = '1;
  localparam logic [LEVEL_W-1:0] LVL_RSVD = LEVEL_W'(2);

  gen_e               gen;
  cls_e               cls;
  logic               xlateBoth;
  logic               hypEntry;
  logic               hypKept;
  logic [LEVEL_W-1:0] guestLvl;
  logic [LEVEL_W-1:0] hypLvl;
  logic [LEVEL_W-1:0] newGuestBase;

  assign gen       = gen_e'(genSel);
  assign cls       = cls_e'(excClass);
  assign xlateBoth = curInstXlate & curDataXlate;
  assign hypEntry  = newHyp & ~curHyp;
  assign hypKept   = (newHyp == curHyp);
  assign newGuestBase = (relocField == LVL_RSVD) ? LVL_ZERO : relocField;

  always_comb begin
    guestLvl = LVL_ZERO;
    hypLvl   = LVL_ZERO;
    unique case (gen)
      GEN_LEGACY: begin
        guestLvl = LVL_ZERO;
        hypLvl   = LVL_ZERO;
      end
      GEN_MID_A, GEN_MID_B: begin
        guestLvl = relocField;
        hypLvl   = relocField;
        if (!xlateBoth) begin
          guestLvl = LVL_ZERO;
          hypLvl   = LVL_ZERO;
        end else if (hypEntry && !radixGuest) begin
          hypLvl = LVL_ZERO;
        end
      end
      GEN_NEW: begin
        guestLvl = newGuestBase;
        hypLvl   = hypRelocEn ? LVL_MAX : LVL_ZERO;
        if (hypKept && !xlateBoth) begin
          guestLvl = LVL_ZERO;
          hypLvl   = LVL_ZERO;
        end
      end
      default: begin
        guestLvl = LVL_ZERO;
        hypLvl   = LVL_ZERO;
      end
    endcase
    if (cls != CLS_ORDINARY) begin
      guestLvl = LVL_ZERO;
      hypLvl   = LVL_ZERO;
    end
  end

  always_comb begin
    strobes.capture = reqValid;
    strobes.sysCall = sysCallVec;
    strobes.level   = newHyp ? hypLvl : guestLvl;
  end

  // Real-mode classes never relocate
  always_comb begin
    if (reqValid && cls != CLS_ORDINARY)
      AST_REALMODE_CLASS: assert (strobes.level == LVL_ZERO); // R2
  end

  // Oldest generation never relocates
  always_comb begin
    if (reqValid && gen == GEN_LEGACY)
      AST_LEGACY_ZERO: assert (strobes.level == LVL_ZERO); // R3
  end

endmodule

// File: rtl/relocsel_dp.sv
module relocsel_dp
  import relocsel_pkg::*;
#(
  parameter int VEC_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [VEC_W-1:0]   baseVector,
  output logic               outValid,
  output logic [LEVEL_W-1:0] outLevel,
  output logic [VEC_W-1:0]   outVector,
  output logic               outXlateOn
);

  localparam logic [VEC_W-1:0] OrdL2   = VEC_W'(OFS_ORD_L2);
  localparam logic [VEC_W-1:0] OrdL3   = VEC_W'(OFS_ORD_L3);
  localparam logic [VEC_W-1:0] ScL3    = VEC_W'(OFS_SC_L3);
  localparam logic [VEC_W-1:0] ScOther = VEC_W'(OFS_SC_OTHER);
  localparam logic [LEVEL_W-1:0] LvlTop = '1;

  logic [VEC_W-1:0] offset;
  logic [VEC_W-1:0] nextVector;
  logic             nextXlate;

  always_comb begin
    offset = '0;
    if (strobes.sysCall) begin
      offset = (strobes.level == LvlTop) ? ScL3 : ScOther;
    end else begin
      unique case (strobes.level)
        2'd2:    offset = OrdL2;
        2'd3:    offset = OrdL3;
        default: offset = '0;
      endcase
    end
  end

  assign nextVector = baseVector | offset;
  assign nextXlate  = |strobes.level;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outLevel   <= '0;
      outVector  <= '0;
      outXlateOn <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) begin
        outLevel   <= strobes.level;
        outVector  <= nextVector;
        outXlateOn <= nextXlate;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(outVector) && $stable(outLevel)); // R1

  AST_VEC_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> ((outVector & $past(baseVector)) == $past(baseVector))); // R9

endmodule

// File: rtl/relocsel_top.sv
module relocsel_top
  import relocsel_pkg::*;
#(
  parameter int VEC_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       genSel,
  input  logic [1:0]       excClass,
  input  logic             curInstXlate,
  input  logic             curDataXlate,
  input  logic             curHyp,
  input  logic             newHyp,
  input  logic [1:0]       relocField,
  input  logic             hypRelocEn,
  input  logic             radixGuest,
  input  logic [VEC_W-1:0] baseVector,
  input  logic             sysCallVec,
  output logic             outValid,
  output logic [1:0]       outLevel,
  output logic [VEC_W-1:0] outVector,
  output logic             outXlateOn
);

  strobe_t strobes;

  relocsel_ctrl i_ctrl (
    .reqValid     (reqValid),
    .genSel       (genSel),
    .excClass     (excClass),
    .curInstXlate (curInstXlate),
    .curDataXlate (curDataXlate),
    .curHyp       (curHyp),
    .newHyp       (newHyp),
    .relocField   (relocField),
    .hypRelocEn   (hypRelocEn),
    .radixGuest   (radixGuest),
    .sysCallVec   (sysCallVec),
    .strobes      (strobes)
  );

  relocsel_dp #(.VEC_W(VEC_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .baseVector (baseVector),
    .outValid   (outValid),
    .outLevel   (outLevel),
    .outVector  (outVector),
    .outXlateOn (outXlateOn)
  );

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid); // R1

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid); // R1

  AST_MID_XLATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (genSel == 2'd1 || genSel == 2'd2) && !(curInstXlate && curDataXlate))
      |=> (outLevel == 2'd0)); // R4

  AST_NEW_HYP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && genSel == 2'd3 && excClass == 2'd0 && !curHyp && newHyp)
      |=> (outLevel == ($past(hypRelocEn) ? 2'd3 : 2'd0))); // R8

  AST_XLATE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outXlateOn == (outLevel != 2'd0))); // R11

endmodule

// File: tb/test_relocsel_top.sv
module test_relocsel_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  genSel = '0;
  logic [1:0]  excClass = '0;
  logic        curInstXlate = 1'b0;
  logic        curDataXlate = 1'b0;
  logic        curHyp = 1'b0;
  logic        newHyp = 1'b0;
  logic [1:0]  relocField = '0;
  logic        hypRelocEn = 1'b0;
  logic        radixGuest = 1'b0;
  logic [63:0] baseVector = '0;
  logic        sysCallVec = 1'b0;
  logic        outValid;
  logic [1:0]  outLevel;
  logic [63:0] outVector;
  logic        outXlateOn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  relocsel_top i_relocsel_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .genSel(genSel),
    .excClass(excClass), .curInstXlate(curInstXlate), .curDataXlate(curDataXlate),
    .curHyp(curHyp), .newHyp(newHyp), .relocField(relocField),
    .hypRelocEn(hypRelocEn), .radixGuest(radixGuest), .baseVector(baseVector),
    .sysCallVec(sysCallVec), .outValid(outValid), .outLevel(outLevel),
    .outVector(outVector), .outXlateOn(outXlateOn)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference written from the requirement list
  function automatic logic [1:0] refLevel(input int gen, input int cls, input bit ir,
      input bit dr, input bit ch, input bit nh, input logic [1:0] fld,
      input bit hen, input bit radix);
    bit xl = ir && dr;
    logic [1:0] g;
    if (cls != 0) return 2'd0;
    if (gen == 0) return 2'd0;
    if (gen == 3) begin
      g = (fld == 2'd2) ? 2'd0 : fld;
      if (nh && !ch) return hen ? 2'd3 : 2'd0;
      if (!nh && ch) return g;
      if (!xl) return 2'd0;
      return nh ? (hen ? 2'd3 : 2'd0) : g;
    end
    if (!xl) return 2'd0;
    if (nh && !ch && !radix) return 2'd0;
    return fld;
  endfunction

  function automatic logic [63:0] refVector(input logic [63:0] b, input logic [1:0] l, input bit sc);
    if (sc) return b | ((l == 2'd3) ? 64'hC000_0000_0000_3000 : 64'h0000_0000_0001_7000);
    case (l)
      2'd2: return b | 64'h0000_0000_0001_8000;
      2'd3: return b | 64'hC000_0000_0000_4000;
      default: return b;
    endcase
  endfunction

  function automatic string levelTag(input int gen, input int cls, input bit ir, input bit dr,
      input bit ch, input bit nh, input logic [1:0] fld);
    if (cls != 0) return "R2";
    if (gen == 0) return "R3";
    if (gen == 3) begin
      if (ch != nh) return "R8";
      if (!nh && fld == 2'd2) return "R7";
      return "R6";
    end
    if (ir && dr && nh && !ch) return "R5";
    return "R4";
  endfunction

  task automatic issue(input int gen, input int cls, input bit ir, input bit dr, input bit ch,
      input bit nh, input logic [1:0] fld, input bit hen, input bit radix,
      input logic [63:0] b, input bit sc);
    @(negedge clk);
    genSel = 2'(gen); excClass = 2'(cls); curInstXlate = ir; curDataXlate = dr;
    curHyp = ch; newHyp = nh; relocField = fld; hypRelocEn = hen; radixGuest = radix;
    baseVector = b; sysCallVec = sc; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset valid", 64'(outValid), 64'd0);
    check("R1 reset level", 64'(outLevel), 64'd0);
    check("R1 reset vector", outVector, 64'd0);
    check("R1 reset xlate", 64'(outXlateOn), 64'd0);
  endtask

  task automatic testPulseHold();
    issue(3, 0, 1, 1, 0, 0, 2'd3, 0, 0, 64'h0000_0000_0000_0900, 0);
    check("R1 valid pulse", 64'(outValid), 64'd1);
    check("R9 level3 vector", outVector, 64'hC000_0000_0000_4900);
    // change inputs without a request
    baseVector = 64'h0000_0000_0000_0E00; relocField = 2'd0;
    @(negedge clk);
    check("R1 valid drops", 64'(outValid), 64'd0);
    check("R1 vector held", outVector, 64'hC000_0000_0000_4900);
    check("R1 level held", 64'(outLevel), 64'd3);
  endtask

  task automatic testDirected();
    // newest generation: reserved field value 2 becomes 0
    issue(3, 0, 1, 1, 0, 0, 2'd2, 1, 0, 64'h0000_0000_0000_0500, 0);
    check("R7 field2 level", 64'(outLevel), 64'd0);
    check("R7 field2 vector", outVector, 64'h0000_0000_0000_0500);
    check("R11 field2 xlate", 64'(outXlateOn), 64'd0);
    // middle generation keeps level 2
    issue(1, 0, 1, 1, 0, 0, 2'd2, 0, 0, 64'h0000_0000_0000_0500, 0);
    check("R9 mid level2 vector", outVector, 64'h0000_0000_0001_8500);
    // system call with level 0 still gets the low offset
    issue(0, 0, 1, 1, 0, 0, 2'd3, 0, 0, 64'h0, 1);
    check("R10 syscall level0 vector", outVector, 64'h0000_0000_0001_7000);
    // level 1 keeps vector, forces translation
    issue(2, 0, 1, 1, 1, 1, 2'd1, 0, 0, 64'h0000_0000_0000_0300, 0);
    check("R9 level1 vector", outVector, 64'h0000_0000_0000_0300);
    check("R11 level1 xlate", 64'(outXlateOn), 64'd1);
    // newest generation hypervisor entry with translation off
    issue(3, 0, 0, 0, 0, 1, 2'd0, 1, 0, 64'h0000_0000_0000_0E00, 1);
    check("R8 hyp entry level", 64'(outLevel), 64'd3);
    check("R10 syscall level3 vector", outVector, 64'hC000_0000_0000_3E00);
  endtask

  task automatic testSweep(input int gen);
    for (int cls = 0; cls < 4; cls++) begin
      for (int combo = 0; combo < 256; combo++) begin
        for (int sc = 0; sc < 2; sc++) begin
          bit ir = combo[0], dr = combo[1], ch = combo[2], nh = combo[3];
          logic [1:0] fld = 2'(combo >> 4);
          bit hen = combo[6], radix = combo[7];
          logic [63:0] b = 64'h0000_0000_0000_0100 * 64'((combo % 15) + 1);
          logic [1:0] el;
          issue(gen, cls, ir, dr, ch, nh, fld, hen, radix, b, sc[0]);
          el = refLevel(gen, cls, ir, dr, ch, nh, fld, hen, radix);
          check({levelTag(gen, cls, ir, dr, ch, nh, fld), " level"}, 64'(outLevel), 64'(el));
          check(sc[0] ? "R10 vector" : "R9 vector", outVector, refVector(b, el, sc[0]));
          check("R11 xlate", 64'(outXlateOn), 64'(el != 2'd0));
          check("R1 valid", 64'(outValid), 64'd1);
        end
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPulseHold();
    testDirected();
    for (int g = 0; g < 4; g++) testSweep(g);
    summary();
  end

endmodule